// File: doc/BRIEF.md
# Alter-Skip Micro-op Unit

This block executes one 16-bit alter-skip word against one of two accumulators and a one-bit extend flag. A single word can combine several micro-operations:

- replace the chosen register with zero, its one's complement or all ones;
- clear, invert or set the extend flag;
- increment the register, with carry into the extend flag and signed overflow detection;
- request a skip from a set of tests whose sense can be reversed.

The operations run in a fixed order. The register is altered first. The extend test then reads the original flag, and the extend alteration follows. The sign and low-bit tests look at the altered register. The increment comes next, and the zero test looks at its result.

A sequencer pulses `start` with the word and the current register and flag values. One cycle later the unit presents both accumulators, the extend flag, the overflow flag and the skip request, and it pulses `done`. These outputs hold until the next start. A word that does not belong to this group leaves every value unchanged and requests no skip. The program counter, memory access and I/O are handled elsewhere.

Top module: `alter_skip_unit`

## Requirements
- R1: A word belongs to the group only when bit 15 is 0, bits 14:12 are 000 and bit 10 is 1. For any other word, both registers, E and overflow pass through unchanged and skip is 0.
- R2: Bit 11 chooses the working register: 0 chooses A and 1 chooses B. The other register passes through unchanged.
- R3: Bits 9:8 alter the working register first: 00 keeps it, 01 clears it, 10 complements it and 11 sets it to all ones.
- R4: Bits 7:6 alter E with the same coding: 00 keeps, 01 clears, 10 complements and 11 sets.
- R5: Bit 2 adds one to the altered register. A carry out of the top bit sets E. With no carry, E keeps its value after alteration.
- R6: The overflow output is set when an increment turns a positive value negative, which happens only for the input 0x7FFF. In every other case it equals the overflow input.
- R7: Each test is enabled by its own bit. Bit 5 tests the original E for 0. Bit 4 tests the altered register's sign bit for 0. Bit 3 tests the altered register's bit 0 for 0. Bit 1 tests the register after the increment for zero. With bit 0 clear, skip is 1 when any enabled test is true.
- R8: With bit 0 set and at least one test enabled, skip is 1 only when every enabled test is false. For example, with bits 4 and 3 enabled, the skip needs both the sign bit and bit 0 equal to 1.
- R9: With bit 0 set and no test enabled, skip is 1 unconditionally.
- R10: The outputs update on the clock edge that samples `start`, and `done` is high for exactly that following cycle. Without `start`, all outputs hold and `done` is 0.
- R11: While reset is active, every output is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Execute the word this cycle |
| instr | input | 16 | Instruction word |
| acc_a | input | W | Current A register |
| acc_b | input | W | Current B register |
| e_in | input | 1 | Current extend flag |
| ovf_in | input | 1 | Current overflow flag |
| a_out | output | W | New A register |
| b_out | output | W | New B register |
| e_out | output | 1 | New extend flag |
| ovf_out | output | 1 | New overflow flag |
| skip | output | 1 | Skip request |
| done | output | 1 | One-cycle result pulse |

## Verification
The assertions assume that the word, the register values and both flags are steady around the edge that samples `start`. They also assume that `start` is a single-cycle request. No assumption is made about the spacing between requests. The bench drives every input at the falling edge and holds it for a full cycle. It raises `start` for one cycle per word and leaves an idle cycle between words, so the hold behaviour is observed after every operation.

// File: rtl/asu_pkg.sv
package asu_pkg;
  localparam int IW = 16;

  typedef enum logic [1:0] {
    ALT_KEEP = 2'b00,
    ALT_CLR  = 2'b01,
    ALT_CMP  = 2'b10,
    ALT_ONES = 2'b11
  } alt_op_e;

  typedef struct packed {
    logic    sel_b;
    alt_op_e r_op;
    alt_op_e e_op;
    logic    t_ez;
    logic    t_sign;
    logic    t_lsb;
    logic    do_inc;
    logic    t_zero;
    logic    rev;
  } asu_fields_t;
endpackage

// File: rtl/asu_decode.sv
module asu_decode
  import asu_pkg::*;
(
  input  logic [IW-1:0] instr,
  output logic          grp_hit,
  output asu_fields_t   fld
);
  always_comb begin
    grp_hit    = (instr[15:12] == 4'b0000) && instr[10];
    fld.sel_b  = instr[11];
    fld.r_op   = alt_op_e'(instr[9:8]);
    fld.e_op   = alt_op_e'(instr[7:6]);
    fld.t_ez   = instr[5];
    fld.t_sign = instr[4];
    fld.t_lsb  = instr[3];
    fld.do_inc = instr[2];
    fld.t_zero = instr[1];
    fld.rev    = instr[0];
  end
endmodule

// File: rtl/asu_datapath.sv
module asu_datapath
  import asu_pkg::*;
#(
  parameter int W = 16
) (
  input  asu_fields_t  fld,
  input  logic [W-1:0] r_in,
  input  logic         e_in,
  input  logic         ovf_in,
  output logic [W-1:0] r_new,
  output logic         e_new,
  output logic         ovf_new,
  output logic         c_ez,
  output logic         c_sign,
  output logic         c_lsb,
  output logic         c_zero,
  output logic         inc_carry,
  output logic         inc_ovf
);
  localparam int MSB = W - 1;

  function automatic logic [W-1:0] f_alter(alt_op_e op, logic [W-1:0] v);
    case (op)
      ALT_CLR:  f_alter = '0;
      ALT_CMP:  f_alter = ~v;
      ALT_ONES: f_alter = '1;
      default:  f_alter = v;
    endcase
  endfunction

  function automatic logic f_alter_bit(alt_op_e op, logic v);
    case (op)
      ALT_CLR:  f_alter_bit = 1'b0;
      ALT_CMP:  f_alter_bit = ~v;
      ALT_ONES: f_alter_bit = 1'b1;
      default:  f_alter_bit = v;
    endcase
  endfunction

  function automatic logic [W:0] f_incr(logic [W-1:0] v);
    f_incr = {1'b0, v} + {{W{1'b0}}, 1'b1};
  endfunction

  logic [W-1:0] r_alt;
  logic         e_alt;
  logic [W:0]   sum;
  logic [W-1:0] r_fin;

  always_comb begin
    r_alt     = f_alter(fld.r_op, r_in);
    c_ez      = ~e_in;
    e_alt     = f_alter_bit(fld.e_op, e_in);
    c_sign    = ~r_alt[MSB];
    c_lsb     = ~r_alt[0];
    sum       = f_incr(r_alt);
    r_fin     = fld.do_inc ? sum[W-1:0] : r_alt;
    inc_carry = fld.do_inc & sum[W];
    inc_ovf   = fld.do_inc & ~r_alt[MSB] & sum[MSB];
    c_zero    = (r_fin == '0);
    r_new     = r_fin;
    e_new     = inc_carry ? 1'b1 : e_alt;
    ovf_new   = ovf_in | inc_ovf;
  end
endmodule

// File: rtl/asu_skip.sv
module asu_skip
  import asu_pkg::*;
(
  input  asu_fields_t fld,
  input  logic        c_ez,
  input  logic        c_sign,
  input  logic        c_lsb,
  input  logic        c_zero,
  output logic        skip_req
);
  logic [3:0] en;
  logic [3:0] cond;
  logic       any_en;
  logic       any_true;

  always_comb begin
    en       = {fld.t_ez, fld.t_sign, fld.t_lsb, fld.t_zero};
    cond     = {c_ez, c_sign, c_lsb, c_zero};
    any_en   = |en;
    any_true = |(en & cond);
    if (!fld.rev)
      skip_req = any_true;
    else if (!any_en)
      skip_req = 1'b1;
    else
      skip_req = ~any_true;
  end
endmodule

// File: rtl/alter_skip_unit.sv
module alter_skip_unit
  import asu_pkg::*;
#(
  parameter int W = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic [IW-1:0] instr,
  input  logic [W-1:0]  acc_a,
  input  logic [W-1:0]  acc_b,
  input  logic          e_in,
  input  logic          ovf_in,
  output logic [W-1:0]  a_out,
  output logic [W-1:0]  b_out,
  output logic          e_out,
  output logic          ovf_out,
  output logic          skip,
  output logic          done
);
  asu_fields_t  fld;
  logic         grp_hit;
  logic [W-1:0] r_sel;
  logic [W-1:0] r_new;
  logic         e_new;
  logic         ovf_new;
  logic         c_ez;
  logic         c_sign;
  logic         c_lsb;
  logic         c_zero;
  logic         inc_carry;
  logic         inc_ovf;
  logic         skip_req;

  asu_decode u_dec (
    .instr   (instr),
    .grp_hit (grp_hit),
    .fld     (fld)
  );

  assign r_sel = fld.sel_b ? acc_b : acc_a;

  asu_datapath #(.W(W)) u_dp (
    .fld       (fld),
    .r_in      (r_sel),
    .e_in      (e_in),
    .ovf_in    (ovf_in),
    .r_new     (r_new),
    .e_new     (e_new),
    .ovf_new   (ovf_new),
    .c_ez      (c_ez),
    .c_sign    (c_sign),
    .c_lsb     (c_lsb),
    .c_zero    (c_zero),
    .inc_carry (inc_carry),
    .inc_ovf   (inc_ovf)
  );

  asu_skip u_skp (
    .fld      (fld),
    .c_ez     (c_ez),
    .c_sign   (c_sign),
    .c_lsb    (c_lsb),
    .c_zero   (c_zero),
    .skip_req (skip_req)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      a_out   <= '0;
      b_out   <= '0;
      e_out   <= 1'b0;
      ovf_out <= 1'b0;
      skip    <= 1'b0;
      done    <= 1'b0;
    end else begin
      done <= start;
      if (start) begin
        if (grp_hit) begin
          a_out   <= fld.sel_b ? acc_a : r_new;
          b_out   <= fld.sel_b ? r_new : acc_b;
          e_out   <= e_new;
          ovf_out <= ovf_new;
          skip    <= skip_req;
        end else begin
          a_out   <= acc_a;
          b_out   <= acc_b;
          e_out   <= e_in;
          ovf_out <= ovf_in;
          skip    <= 1'b0;
        end
      end
    end
  end
endmodule

// File: rtl/asu_checker.sv
module asu_checker #(
  parameter int W = 16
) (
  input logic         clk,
  input logic         rst_n,
  input logic         start,
  input logic [15:0]  instr,
  input logic [W-1:0] acc_a,
  input logic [W-1:0] acc_b,
  input logic         e_in,
  input logic         ovf_in,
  input logic [W-1:0] a_out,
  input logic [W-1:0] b_out,
  input logic         e_out,
  input logic         ovf_out,
  input logic         skip,
  input logic         done,
  input logic         grp_hit,
  input logic         inc_carry,
  input logic         inc_ovf
);
  p_foreign_word_r1: assert property (@(posedge clk) disable iff (!rst_n)
    start && !grp_hit |=> !skip && a_out == $past(acc_a) && b_out == $past(acc_b)
                          && e_out == $past(e_in) && ovf_out == $past(ovf_in));

  p_other_reg_a_r2: assert property (@(posedge clk) disable iff (!rst_n)
    start && grp_hit && !instr[11] |=> b_out == $past(acc_b));

  p_other_reg_b_r2: assert property (@(posedge clk) disable iff (!rst_n)
    start && grp_hit && instr[11] |=> a_out == $past(acc_a));

  p_carry_sets_e_r5: assert property (@(posedge clk) disable iff (!rst_n)
    start && grp_hit && inc_carry |=> e_out);

  p_ovf_set_r6: assert property (@(posedge clk) disable iff (!rst_n)
    start && grp_hit && inc_ovf |=> ovf_out);

  p_no_overflow_r6: assert property (@(posedge clk) disable iff (!rst_n)
    start && !inc_ovf |=> ovf_out == $past(ovf_in));

  p_rss_alone_r9: assert property (@(posedge clk) disable iff (!rst_n)
    start && grp_hit && instr[0] && instr[5:3] == 3'b000 && !instr[1] |=> skip);

  p_done_pulse_r10: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> done);

  p_idle_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !start |=> !done && $stable(a_out) && $stable(b_out) && $stable(e_out)
               && $stable(ovf_out) && $stable(skip));

  always_comb begin
    if (!rst_n) begin
      p_reset_r11: assert (a_out == '0 && b_out == '0 && !e_out && !ovf_out && !skip && !done);
    end
  end
endmodule

bind alter_skip_unit asu_checker #(.W(W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .start     (start),
  .instr     (instr),
  .acc_a     (acc_a),
  .acc_b     (acc_b),
  .e_in      (e_in),
  .ovf_in    (ovf_in),
  .a_out     (a_out),
  .b_out     (b_out),
  .e_out     (e_out),
  .ovf_out   (ovf_out),
  .skip      (skip),
  .done      (done),
  .grp_hit   (grp_hit),
  .inc_carry (inc_carry),
  .inc_ovf   (inc_ovf)
);

// File: tb/alter_skip_unit_tb.sv
module alter_skip_unit_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [15:0] instr = '0;
  logic [15:0] acc_a = '0;
  logic [15:0] acc_b = '0;
  logic        e_in = 1'b0;
  logic        ovf_in = 1'b0;
  logic [15:0] a_out, b_out;
  logic        e_out, ovf_out, skip, done;

  int checks = 0;
  int errors = 0;

  always #10 clk = ~clk;

  alter_skip_unit #(.W(16)) u_dut (
    .clk(clk), .rst_n(rst_n), .start(start), .instr(instr),
    .acc_a(acc_a), .acc_b(acc_b), .e_in(e_in), .ovf_in(ovf_in),
    .a_out(a_out), .b_out(b_out), .e_out(e_out), .ovf_out(ovf_out),
    .skip(skip), .done(done)
  );

  task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  // Reference: returns {skip, ovf, e, b, a}
  function automatic logic [34:0] model(input logic [15:0] w, input logic [15:0] a,
                                        input logic [15:0] b, input logic e, input logic o);
    logic [15:0] r;
    logic        ee, oo, e_zero, s_pos, l_even, z, hit, sel, sk;
    int          t;
    if (w[15] || w[14:12] != 3'd0 || !w[10])
      return {1'b0, o, e, b, a};               // R1
    sel = w[11];                               // R2
    r = sel ? b : a;
    if (w[9:8] == 2'd1) r = 16'h0000;          // R3
    else if (w[9:8] == 2'd2) r = r ^ 16'hFFFF;
    else if (w[9:8] == 2'd3) r = 16'hFFFF;
    e_zero = (e == 1'b0);                      // R7: original E
    ee = e;
    if (w[7:6] == 2'd1) ee = 1'b0;             // R4
    else if (w[7:6] == 2'd2) ee = !e;
    else if (w[7:6] == 2'd3) ee = 1'b1;
    s_pos  = (r[15] == 1'b0);
    l_even = (r[0] == 1'b0);
    oo = o;
    if (w[2]) begin                            // R5, R6
      t = int'(r) + 1;
      if (t > 65535) ee = 1'b1;
      if (r == 16'h7FFF) oo = 1'b1;
      r = t[15:0];
    end
    z = (r == 16'h0000);
    hit = (w[5] && e_zero) || (w[4] && s_pos) || (w[3] && l_even) || (w[1] && z);
    if (!w[0]) sk = hit;                                  // R7
    else if (w[5:3] == 3'd0 && !w[1]) sk = 1'b1;          // R9
    else sk = !hit;                                       // R8
    if (sel) return {sk, oo, ee, r, a};
    return {sk, oo, ee, b, r};
  endfunction

  task automatic run_op(input string req, input logic [15:0] w, input logic [15:0] a,
                        input logic [15:0] b, input logic e, input logic o);
    logic [34:0] exp;
    logic [15:0] ha, hb;
    @(negedge clk);
    instr = w; acc_a = a; acc_b = b; e_in = e; ovf_in = o; start = 1'b1;
    exp = model(w, a, b, e, o);
    @(negedge clk);
    start = 1'b0;
    chk(req, "a_out", {16'h0, a_out}, {16'h0, exp[15:0]});
    chk(req, "b_out", {16'h0, b_out}, {16'h0, exp[31:16]});
    chk(req, "e_out", {31'h0, e_out}, {31'h0, exp[32]});
    chk(req, "ovf_out", {31'h0, ovf_out}, {31'h0, exp[33]});
    chk(req, "skip", {31'h0, skip}, {31'h0, exp[34]});
    chk("R10", "done", {31'h0, done}, 32'h1);
    ha = a_out; hb = b_out;
    instr = $urandom(); acc_a = $urandom(); acc_b = $urandom(); e_in = !e_in;
    @(negedge clk);
    chk("R10", "done idle", {31'h0, done}, 32'h0);
    chk("R10", "hold a/b", {a_out, b_out}, {ha, hb});
    chk("R10", "hold e/ovf/skip", {29'h0, e_out, ovf_out, skip}, {29'h0, exp[32], exp[33], exp[34]});
  endtask

  initial begin
    #3_000_000;
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    repeat (2) @(negedge clk);
    chk("R11", "reset outputs", {a_out[7:0], b_out[7:0], 10'h0, e_out, ovf_out, skip, done}, 32'h0);
    rst_n = 1'b1;
    // Directed corner cases
    run_op("R1", 16'h8400, 16'h1234, 16'h5678, 1'b1, 1'b0);   // bit 15 set
    run_op("R1", 16'h0300, 16'h1234, 16'h5678, 1'b0, 1'b1);   // bit 10 clear
    run_op("R2", 16'h0E00, 16'h1234, 16'h5678, 1'b0, 1'b0);   // complement B
    run_op("R3", 16'h0500, 16'hBEEF, 16'h0001, 1'b0, 1'b0);   // clear A
    run_op("R3", 16'h0700, 16'h0000, 16'h0002, 1'b0, 1'b0);   // ones A
    run_op("R4", 16'h04C0, 16'h0000, 16'h0000, 1'b0, 1'b0);   // set E
    run_op("R4", 16'h0480, 16'h0000, 16'h0000, 1'b1, 1'b0);   // complement E
    run_op("R5", 16'h0404, 16'hFFFF, 16'h0000, 1'b0, 1'b0);   // carry out
    run_op("R5", 16'h0444, 16'h0010, 16'h0000, 1'b1, 1'b0);   // clear E, no carry
    run_op("R6", 16'h0404, 16'h7FFF, 16'h0000, 1'b0, 1'b0);   // signed overflow
    run_op("R6", 16'h0C04, 16'h0000, 16'h8000, 1'b0, 1'b1);   // ovf stays set
    run_op("R7", 16'h0460, 16'h0000, 16'h0000, 1'b0, 1'b0);   // E test before clear
    run_op("R7", 16'h0406, 16'hFFFF, 16'h0000, 1'b0, 1'b0);   // zero after increment
    run_op("R8", 16'h0419, 16'h8001, 16'h0000, 1'b0, 1'b0);   // sign+lsb reversed, skip
    run_op("R8", 16'h0419, 16'h8000, 16'h0000, 1'b0, 1'b0);   // sign+lsb reversed, none
    run_op("R9", 16'h0401, 16'h1234, 16'h0000, 1'b1, 1'b0);   // reverse alone
    // Constrained random
    for (int i = 0; i < 400; i++) begin
      logic [15:0] w, a, b;
      int pick;
      w = $urandom();
      if (($urandom() % 4) != 0) begin w[15:12] = 4'h0; w[10] = 1'b1; end
      pick = $urandom() % 5;
      a = (pick == 0) ? 16'h7FFF : (pick == 1) ? 16'hFFFF : (pick == 2) ? 16'h0000 : 16'($urandom());
      b = (pick == 3) ? 16'h7FFF : 16'($urandom());
      run_op(w[0] ? "R8" : "R7", w, a, b, 1'($urandom()), 1'($urandom()));
    end
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule